// File: doc/BRIEF.md
# Descriptor-then-Data Receive Sink

This block sits on the application side of a packet receive path. Each transaction arrives in two parts. First a 136-bit descriptor is offered with a request line. The block acknowledges it with a single-cycle pulse and captures it into three output fields. If the transaction carries data, a data-phase framing line then frames a run of 64-bit payload words. Each word carries eight byte enables.

Both ends can pause the payload. The sender stalls by lowering data-valid. The block stalls by raising its own wait-state output, which a parameterised pseudo-random generator drives. A word moves only when data-valid is high and wait-state is low. Accepted words leave on a plain output stream marked with first and last flags. The block holds back one word so that it can tag the final word of a packet when the framing line drops. The framing line may drop for a single cycle between two packets, and the block then reports them as two packets.

Top module: `rx_desc_sink`

## Requirements
- R1: One cycle after the acknowledge pulse, `desc_vld_o` pulses for one cycle. At that point `desc_hdr_o` holds `desc_i[135:128]`, `desc_hi_o` holds `desc_i[127:64]` and `desc_lo_o` holds `desc_i[63:0]`, all as sampled during the acknowledge cycle. The fields then keep their value until the next capture.
- R2: A request sampled high while the block is idle raises `ack_o` on the next cycle, for exactly one cycle. No further acknowledge is given until `req_i` has been seen low.
- R3: Payload acceptance does not depend on the descriptor handshake. The framing line may rise in the same cycle as the request or later.
- R4: A payload word is accepted at a clock edge only when `frame_i`, `dv_i` and the low state of `ws_o` all hold. In any other cycle no word is taken and the stream does not advance.
- R5: Every accepted word appears exactly once on the output stream, in order, with its byte enables unchanged (0xFF, 0x0F and 0xF0 are all passed through as given). A word is emitted in the cycle after the next word is accepted, or in the cycle after `frame_i` is sampled low.
- R6: `out_first_o` marks the first accepted word of a packet. `out_last_o` marks the final word accepted before `frame_i` falls. A packet of one word carries both flags. Neither flag is ever high without `out_valid_o`.
- R7: If `frame_i` is low for a single cycle between two runs of high, the block treats the two runs as two separate packets, each with its own first and last words.
- R8: With `WS_MODE`=1, `ws_o` is a registered pseudo-random pattern. Its density is set by `WS_THRESH` out of 2^`WS_THR_W`, and it may be high in any cycle. With `WS_MODE`=0, `ws_o` is held low.
- R9: A synchronous reset clears `ack_o`, `ws_o`, `desc_vld_o` and `out_valid_o` to low, and discards any word being held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Descriptor request |
| desc_i | input | 136 | Descriptor bus |
| ack_o | output | 1 | Descriptor acknowledge pulse |
| desc_vld_o | output | 1 | Captured-descriptor strobe |
| desc_hdr_o | output | 8 | Captured top field |
| desc_hi_o | output | 64 | Captured middle field |
| desc_lo_o | output | 64 | Captured low field |
| frame_i | input | 1 | Data-phase framing |
| dv_i | input | 1 | Payload data valid |
| data_i | input | 64 | Payload word |
| be_i | input | 8 | Payload byte enables |
| ws_o | output | 1 | Receiver wait state |
| out_valid_o | output | 1 | Output word strobe |
| out_data_o | output | 64 | Output word |
| out_be_o | output | 8 | Output byte enables |
| out_first_o | output | 1 | First word of packet |
| out_last_o | output | 1 | Last word of packet |

## Verification
The bench builds the block with `WS_MODE`=1 and `WS_THRESH`=5 of 16. The wait-state output is therefore high in roughly a third of all cycles, so receiver stalls land at the start, the middle and the end of payloads. Those stalls combine with the random drops of data-valid from the bench. This reaches the cases where both ends stall at the same time and where a stall falls on the last word just before the framing line drops. The default 136/64-bit geometry exercises the real field split of the descriptor.

// File: rtl/rx_sink_pkg.sv
package rx_sink_pkg;

   typedef enum logic [1:0] {
      DS_IDLE = 2'd0,
      DS_ACK  = 2'd1,
      DS_WAIT = 2'd2
   } desc_st_e;

   localparam int unsigned WS_OFF  = 0;
   localparam int unsigned WS_LFSR = 1;

endpackage

// File: rtl/rx_desc_capture.sv
module rx_desc_capture
   import rx_sink_pkg::*;
#(
   parameter int unsigned DESC_W = 136,
   parameter int unsigned HDR_W  = 8,
   parameter int unsigned MID_W  = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic [DESC_W-1:0] desc_i,
   output logic              ack_o,
   output logic              vld_o,
   output logic [HDR_W-1:0]  hdr_o,
   output logic [MID_W-1:0]  mid_o,
   output logic [DESC_W-HDR_W-MID_W-1:0] low_o
);
   localparam int unsigned LOW_W = DESC_W - HDR_W - MID_W;

   desc_st_e st_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= DS_IDLE;
         ack_o <= 1'b0;
         vld_o <= 1'b0;
         hdr_o <= '0;
         mid_o <= '0;
         low_o <= '0;
      end else begin
         vld_o <= 1'b0;
         ack_o <= 1'b0;
         unique case (st_q)
            DS_IDLE: begin
               if (req_i) begin
                  ack_o <= 1'b1;
                  st_q  <= DS_ACK;
               end
            end
            DS_ACK: begin
               hdr_o <= desc_i[DESC_W-1 -: HDR_W];
               mid_o <= desc_i[LOW_W +: MID_W];
               low_o <= desc_i[LOW_W-1:0];
               vld_o <= 1'b1;
               st_q  <= req_i ? DS_WAIT : DS_IDLE;
            end
            DS_WAIT: begin
               if (!req_i) st_q <= DS_IDLE;
            end
            default: st_q <= DS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rx_ws_gen.sv
module rx_ws_gen
   import rx_sink_pkg::*;
#(
   parameter int unsigned WS_MODE   = WS_LFSR,
   parameter int unsigned LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter int unsigned WS_THR_W  = 4,
   parameter int unsigned WS_THRESH = 5
) (
   input  logic clk,
   input  logic rst,
   output logic ws_o
);
   generate
      if (WS_MODE == WS_OFF) begin : g_off
         always_ff @(posedge clk) begin
            ws_o <= 1'b0;
         end
      end else begin : g_lfsr
         logic [LFSR_W-1:0] lfsr_q;
         logic [LFSR_W-1:0] lfsr_d;

         always_comb begin
            lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]};
            if (lfsr_q[0]) lfsr_d = lfsr_d ^ LFSR_TAPS;
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               lfsr_q <= LFSR_SEED;
               ws_o   <= 1'b0;
            end else begin
               lfsr_q <= lfsr_d;
               ws_o   <= ({1'b0, lfsr_q[WS_THR_W-1:0]} < (WS_THR_W+1)'(WS_THRESH));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rx_payload_track.sv
module rx_payload_track #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_i,
   input  logic              dv_i,
   input  logic              ws_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [BE_W-1:0]   be_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic [BE_W-1:0]   out_be_o,
   output logic              out_first_o,
   output logic              out_last_o
);
   logic              take;
   logic              hold_v_q;
   logic              hold_first_q;
   logic [DATA_W-1:0] hold_data_q;
   logic [BE_W-1:0]   hold_be_q;
   logic              started_q;

   assign take = frame_i & dv_i & ~ws_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_v_q     <= 1'b0;
         hold_first_q <= 1'b0;
         hold_data_q  <= '0;
         hold_be_q    <= '0;
         started_q    <= 1'b0;
         out_valid_o  <= 1'b0;
         out_data_o   <= '0;
         out_be_o     <= '0;
         out_first_o  <= 1'b0;
         out_last_o   <= 1'b0;
      end else begin
         out_valid_o <= 1'b0;
         out_first_o <= 1'b0;
         out_last_o  <= 1'b0;
         if (take) begin
            if (hold_v_q) begin
               out_valid_o <= 1'b1;
               out_data_o  <= hold_data_q;
               out_be_o    <= hold_be_q;
               out_first_o <= hold_first_q;
            end
            hold_v_q     <= 1'b1;
            hold_data_q  <= data_i;
            hold_be_q    <= be_i;
            hold_first_q <= ~started_q;
            started_q    <= 1'b1;
         end else if (!frame_i) begin
            if (hold_v_q) begin
               out_valid_o <= 1'b1;
               out_data_o  <= hold_data_q;
               out_be_o    <= hold_be_q;
               out_first_o <= hold_first_q;
               out_last_o  <= 1'b1;
            end
            hold_v_q  <= 1'b0;
            started_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rx_desc_sink.sv
module rx_desc_sink
   import rx_sink_pkg::*;
#(
   parameter int unsigned DESC_W    = 136,
   parameter int unsigned HDR_W     = 8,
   parameter int unsigned MID_W     = 64,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned WS_MODE   = WS_LFSR,
   parameter int unsigned LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter int unsigned WS_THR_W  = 4,
   parameter int unsigned WS_THRESH = 5
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      req_i,
   input  logic [DESC_W-1:0]         desc_i,
   output logic                      ack_o,
   output logic                      desc_vld_o,
   output logic [HDR_W-1:0]          desc_hdr_o,
   output logic [MID_W-1:0]          desc_hi_o,
   output logic [DESC_W-HDR_W-MID_W-1:0] desc_lo_o,
   input  logic                      frame_i,
   input  logic                      dv_i,
   input  logic [DATA_W-1:0]         data_i,
   input  logic [DATA_W/8-1:0]       be_i,
   output logic                      ws_o,
   output logic                      out_valid_o,
   output logic [DATA_W-1:0]         out_data_o,
   output logic [DATA_W/8-1:0]       out_be_o,
   output logic                      out_first_o,
   output logic                      out_last_o
);
   localparam int unsigned BE_W  = DATA_W / 8;
   localparam int unsigned LOW_W = DESC_W - HDR_W - MID_W;

   generate
      if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_data
         $error("DATA_W must be a nonzero multiple of 8");
      end
      if (HDR_W + MID_W >= DESC_W) begin : g_bad_desc
         $error("descriptor fields leave no low field");
      end
      if (WS_MODE > WS_LFSR) begin : g_bad_mode
         $error("WS_MODE must be 0 or 1");
      end
      if (WS_THR_W == 0 || WS_THR_W > LFSR_W) begin : g_bad_thr
         $error("WS_THR_W must be within the LFSR width");
      end
      if (LOW_W == 0) begin : g_bad_low
         $error("low field is empty");
      end
   endgenerate

   rx_desc_capture #(
      .DESC_W (DESC_W),
      .HDR_W  (HDR_W),
      .MID_W  (MID_W)
   ) i_capture (
      .clk    (clk),
      .rst    (rst),
      .req_i  (req_i),
      .desc_i (desc_i),
      .ack_o  (ack_o),
      .vld_o  (desc_vld_o),
      .hdr_o  (desc_hdr_o),
      .mid_o  (desc_hi_o),
      .low_o  (desc_lo_o)
   );

   rx_ws_gen #(
      .WS_MODE   (WS_MODE),
      .LFSR_W    (LFSR_W),
      .LFSR_TAPS (LFSR_TAPS),
      .LFSR_SEED (LFSR_SEED),
      .WS_THR_W  (WS_THR_W),
      .WS_THRESH (WS_THRESH)
   ) i_ws (
      .clk  (clk),
      .rst  (rst),
      .ws_o (ws_o)
   );

   rx_payload_track #(
      .DATA_W (DATA_W),
      .BE_W   (BE_W)
   ) i_track (
      .clk         (clk),
      .rst         (rst),
      .frame_i     (frame_i),
      .dv_i        (dv_i),
      .ws_i        (ws_o),
      .data_i      (data_i),
      .be_i        (be_i),
      .out_valid_o (out_valid_o),
      .out_data_o  (out_data_o),
      .out_be_o    (out_be_o),
      .out_first_o (out_first_o),
      .out_last_o  (out_last_o)
   );

endmodule

// File: rtl/rx_desc_sink_chk.sv
module rx_desc_sink_chk (
   input logic        clk,
   input logic        rst,
   input logic        req_i,
   input logic        ack_o,
   input logic        desc_vld_o,
   input logic [63:0] desc_lo_o,
   input logic        frame_i,
   input logic        dv_i,
   input logic        ws_o,
   input logic        out_valid_o,
   input logic        out_first_o,
   input logic        out_last_o
);
   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      ack_o |=> !ack_o); // R2

   AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
      ack_o |-> $past(req_i)); // R2

   AST_DESC_STROBE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
      desc_vld_o |-> $past(ack_o)); // R1

   AST_DESC_HELD: assert property (@(posedge clk) disable iff (rst)
      !desc_vld_o |-> $stable(desc_lo_o)); // R1

   AST_EMIT_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !out_last_o) |-> $past(frame_i && dv_i && !ws_o)); // R4

   AST_LAST_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      out_last_o |-> $past(!frame_i)); // R6

   AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
      (out_first_o || out_last_o) |-> out_valid_o); // R6

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!ack_o && !ws_o && !out_valid_o && !desc_vld_o)); // R9

endmodule

bind rx_desc_sink rx_desc_sink_chk i_chk (
   .clk         (clk),
   .rst         (rst),
   .req_i       (req_i),
   .ack_o       (ack_o),
   .desc_vld_o  (desc_vld_o),
   .desc_lo_o   (desc_lo_o),
   .frame_i     (frame_i),
   .dv_i        (dv_i),
   .ws_o        (ws_o),
   .out_valid_o (out_valid_o),
   .out_first_o (out_first_o),
   .out_last_o  (out_last_o)
);

// File: tb/test_rx_desc_sink.sv
module test_rx_desc_sink;
   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_i = 1'b0;
   logic [135:0] desc_i = '0;
   logic         ack_o, desc_vld_o;
   logic [7:0]   desc_hdr_o;
   logic [63:0]  desc_hi_o, desc_lo_o;
   logic         frame_i = 1'b0, dv_i = 1'b0;
   logic [63:0]  data_i = '0;
   logic [7:0]   be_i = '0;
   logic         ws_o, out_valid_o, out_first_o, out_last_o;
   logic [63:0]  out_data_o;
   logic [7:0]   out_be_o;

   int n_chk = 0, n_err = 0;
   int n_ack = 0, n_req = 0, n_last = 0, n_pkt = 0;
   int ws_hi = 0, ws_lo = 0;
   bit finished = 0;

   // bench prediction state
   bit          exp_emit = 0;
   logic [63:0] exp_data;
   logic [7:0]  exp_be;
   bit          exp_first, exp_last;
   bit          h_v = 0, h_first = 0, started = 0;
   logic [63:0] h_data;
   logic [7:0]  h_be;

   always #(CLK_P/2) clk = ~clk;

   rx_desc_sink #(.WS_MODE(1), .WS_THRESH(5)) i_rx_desc_sink (
      .clk(clk), .rst(rst), .req_i(req_i), .desc_i(desc_i), .ack_o(ack_o),
      .desc_vld_o(desc_vld_o), .desc_hdr_o(desc_hdr_o), .desc_hi_o(desc_hi_o),
      .desc_lo_o(desc_lo_o), .frame_i(frame_i), .dv_i(dv_i), .data_i(data_i),
      .be_i(be_i), .ws_o(ws_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
      .out_be_o(out_be_o), .out_first_o(out_first_o), .out_last_o(out_last_o)
   );

   function automatic logic [7:0] pick_be(input int idx, input int n);
      int r = $urandom % 3;
      if (idx == 0 && r == 0) return 8'hF0;
      if (idx == n - 1 && r == 1) return 8'h0F;
      return 8'hFF;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // output checks, then prediction for the coming edge
   always @(negedge clk) begin
      if (ack_o) n_ack++;
      if (out_last_o && out_valid_o) n_last++;
      if (rst) begin
         exp_emit = 0; h_v = 0; started = 0;
      end else begin
         if (frame_i) begin
            if (ws_o) ws_hi++; else ws_lo++;
         end
         check("R4 out_valid", 64'(out_valid_o), 64'(exp_emit));
         if (exp_emit && out_valid_o) begin
            check("R5 data", out_data_o, exp_data);
            check("R5 be", 64'(out_be_o), 64'(exp_be));
            check("R6 first", 64'(out_first_o), 64'(exp_first));
            check("R6 last", 64'(out_last_o), 64'(exp_last));
         end
         exp_emit = 0;
         if (frame_i && dv_i && !ws_o) begin
            if (h_v) begin
               exp_emit = 1; exp_data = h_data; exp_be = h_be;
               exp_first = h_first; exp_last = 0;
            end
            h_v = 1; h_data = data_i; h_be = be_i;
            h_first = !started; started = 1;
         end else if (!frame_i) begin
            if (h_v) begin
               exp_emit = 1; exp_data = h_data; exp_be = h_be;
               exp_first = h_first; exp_last = 1;
            end
            h_v = 0; started = 0;
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic send_word(input logic [63:0] d, input logic [7:0] b);
      bit done = 0;
      while (!done) begin
         if ($urandom % 4 == 0) begin
            dv_i = 1'b0;
            tick();
         end else begin
            dv_i = 1'b1; data_i = d; be_i = b;
            @(negedge clk);
            done = !ws_o;
            tick();
         end
      end
      dv_i = 1'b0;
   endtask

   task automatic send_pkt(input int n, input int gap);
      frame_i = 1'b1;
      for (int i = 0; i < n; i++) send_word({$urandom, $urandom}, pick_be(i, n));
      frame_i = 1'b0;
      n_pkt++;
      for (int g = 0; g < gap; g++) tick();
   endtask

   task automatic send_desc(input logic [135:0] d, input int hold);
      req_i = 1'b1; desc_i = d;
      @(negedge clk);
      while (!ack_o) @(negedge clk);
      tick();
      if (hold == 0) req_i = 1'b0;
      @(negedge clk);
      check("R1 desc_vld", 64'(desc_vld_o), 64'd1);
      check("R1 hdr", 64'(desc_hdr_o), 64'(d[135:128]));
      check("R1 hi", desc_hi_o, d[127:64]);
      check("R1 lo", desc_lo_o, d[63:0]);
      check("R2 ack dropped", 64'(ack_o), 64'd0);
      tick();
      for (int h = 0; h < hold; h++) tick();
      req_i = 1'b0;
      tick();
      n_req++;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) tick();
      @(negedge clk);
      check("R9 ack reset", 64'(ack_o), 64'd0);
      check("R9 ws reset", 64'(ws_o), 64'd0);
      check("R9 out_valid reset", 64'(out_valid_o), 64'd0);
      check("R9 desc_vld reset", 64'(desc_vld_o), 64'd0);
      tick();
      rst = 1'b0;
      tick();

      // R1 / R2 directed: plain request, then one held long
      send_desc({8'hA5, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, 0);
      send_desc({8'h3C, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888}, 4);
      check("R2 one ack per request", 64'(n_ack), 64'(n_req));

      // R3: framing rises in the same cycle as the request
      fork
         send_desc({$urandom, $urandom, $urandom, $urandom, $urandom}[135:0], 1);
         send_pkt(4, 2);
      join

      // R6 single-word packet; R7 back-to-back packets with one low cycle
      send_pkt(1, 1);
      send_pkt(3, 1);
      send_pkt(2, 1);
      send_pkt(1, 3);

      // empty frame: no output expected (R4)
      frame_i = 1'b1; tick(); tick(); frame_i = 1'b0; tick(); tick();

      // constrained random packets
      for (int p = 0; p < 80; p++) send_pkt(1 + $urandom % 8, ($urandom % 3 == 0) ? 1 : 1 + $urandom % 4);

      // R9: reset while a word is held back
      frame_i = 1'b1;
      send_word(64'hDEAD_BEEF_0000_0001, 8'hFF);
      rst = 1'b1; frame_i = 1'b0;
      tick();
      @(negedge clk);
      check("R9 out_valid in reset", 64'(out_valid_o), 64'd0);
      tick();
      rst = 1'b0;
      repeat (4) tick();

      check("R7 last markers per packet", 64'(n_last), 64'(n_pkt));
      check("R8 ws seen high in frame", 64'(ws_hi > 0), 64'd1);
      check("R8 ws seen low in frame", 64'(ws_lo > 0), 64'd1);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

endmodule